// File: doc/BRIEF.md
# Fused Read-Modify-Write ALU Sequencer

This block is the execution datapath for a family of combined instructions in an 8-bit accumulator processor. In most of these instructions a memory byte is modified first. The modify step is an arithmetic left shift, a rotate, a logical right shift, an increment or a decrement. The modified byte is then written back and used as the operand of a second, accumulator-side operation. Other instructions in the family merge registers with AND. Their results go to memory, to the stack pointer, or to several registers at once. Two further instructions apply an immediate AND and then shift or rotate the accumulator.

A caller pulses `start` while the block is idle. With that pulse it presents the operation code, the memory (or immediate) byte, the registers A, X and S, the carry flag and a high-address byte. These inputs are sampled on that edge. In the next cycle the block drives any memory write with a one-cycle strobe. In the cycle after that it raises `done` for one cycle. During that `done` cycle it presents the new register values with write enables and the new flag values with a per-flag update mask. Address generation, bus timing and decimal arithmetic belong to the surrounding core.

Top module: `rmw_fuse_alu`

## Requirements
- R1: `start` is sampled while idle. `wr_en` can be high only in the cycle after that sample, and `done` is high for exactly the cycle after that. Register enables and `flag_we` are nonzero only while `done` is high. `flag_we` bits are {N,Z,C,V} from bit 3 down to bit 0. N is the result's top bit and Z is set when the result is zero.
- R2: A `start` seen while an operation is in progress is ignored. The running operation completes unchanged and no second operation follows.
- R3: Op 0: the byte is shifted left (C = old bit 7) and written back, then A = A OR new byte. Op 1: the byte is rotated left through C and written back, then A = A AND new byte. Op 2: the byte is shifted right (C = old bit 0) and written back, then A = A XOR new byte. For these three ops, flags N, Z and C are updated.
- R4: Op 3: the byte is rotated right through C and written back. Then A = A + new byte + carry out of the rotate. N, Z, C and V are updated, with V set on signed overflow.
- R5: Op 4: the byte is decremented and written back. A is compared with the new byte: C = (A >= byte), with N and Z taken from A minus byte. A is not written.
- R6: Op 5: the byte is incremented and written back. Then A = A - new byte - (1 - C). N, Z, C (set when there is no borrow) and V are updated.
- R7: Op 6: A AND X is written to memory. No register or flag is updated.
- R8: Op 7: the byte is loaded into both A and X, with N and Z updated. Nothing is written to memory.
- R9: Op 8: S becomes A AND X, and S AND (high byte + 1, modulo 256) is written to memory. No flags are updated.
- R10: Op 9: X AND (high byte + 1, modulo 256) is written to memory. No register or flag is updated.
- R11: Op 10: byte AND S is loaded into A, X and S, with N and Z updated.
- R12: Op 11: X = (A AND X) - immediate byte. N and Z come from the new X. C is set when there is no borrow.
- R13: Op 12: A = (A AND byte) shifted right, with C = bit 0 of the AND. Op 13: A = (A AND byte) rotated right through C, with C = bit 0 of the AND. N, Z and C are updated for both.
- R14: Ops 14 and 15 still produce `done`, but they cause no memory write, no register enable and no flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 4 | Operation code |
| mem_in | input | W | Memory operand or immediate byte |
| a_in | input | W | Accumulator |
| x_in | input | W | X register |
| s_in | input | W | Stack pointer |
| c_in | input | 1 | Carry flag |
| hi_in | input | W | High-address byte |
| wr_en | output | 1 | Memory write strobe |
| wr_data | output | W | Byte to write back |
| a_out | output | W | New accumulator |
| a_we | output | 1 | Accumulator write enable |
| x_out | output | W | New X |
| x_we | output | 1 | X write enable |
| s_out | output | W | New stack pointer |
| s_we | output | 1 | Stack pointer write enable |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| c_out | output | 1 | Carry flag |
| v_out | output | 1 | Overflow flag |
| flag_we | output | 4 | Flag update mask {N,Z,C,V} |
| done | output | 1 | Result valid, one cycle |

## Verification
The bench builds the block at its default width of 8 bits. At that width the interesting edges are easy to hit with hand-picked bytes: the 0x7F/0x80 signed boundary for overflow, the 0x00/0xFF wrap of increment and decrement, and the high byte 0xFF whose increment wraps to zero. Each operation is driven with operands chosen so that a wrong carry chain, a wrong flag mask or a swapped operand changes an observed output. A start pulse repeated during a running operation checks that the sequencer ignores it.

// File: rtl/rmw_fuse_alu.sv
module rmw_fuse_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] mem_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] s_in,
  input  logic         c_in,
  input  logic [W-1:0] hi_in,
  output logic         wr_en,
  output logic [W-1:0] wr_data,
  output logic [W-1:0] a_out,
  output logic         a_we,
  output logic [W-1:0] x_out,
  output logic         x_we,
  output logic [W-1:0] s_out,
  output logic         s_we,
  output logic         n_out,
  output logic         z_out,
  output logic         c_out,
  output logic         v_out,
  output logic [3:0]   flag_we,
  output logic         done
);
  localparam int MSB = W - 1;
  localparam logic [3:0] OP_SLO = 4'd0, OP_RLA = 4'd1, OP_SRE = 4'd2, OP_RRA = 4'd3,
                         OP_DCP = 4'd4, OP_ISB = 4'd5, OP_SAX = 4'd6, OP_LAX = 4'd7,
                         OP_SHS = 4'd8, OP_SHX = 4'd9, OP_LAS = 4'd10, OP_SBX = 4'd11,
                         OP_ALR = 4'd12, OP_ARR = 4'd13;

  typedef enum logic [1:0] {ST_IDLE, ST_MOD, ST_ACC} state_t;
  state_t state;

  logic [3:0]   op_q;
  logic [W-1:0] m_q, a_q, x_q, s_q, h_q;
  logic         c_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= '0;
      m_q   <= '0;
      a_q   <= '0;
      x_q   <= '0;
      s_q   <= '0;
      h_q   <= '0;
      c_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_MOD;
          op_q  <= op;
          m_q   <= mem_in;
          a_q   <= a_in;
          x_q   <= x_in;
          s_q   <= s_in;
          h_q   <= hi_in;
          c_q   <= c_in;
        end
        ST_MOD:  state <= ST_ACC;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // modify step
  logic [W-1:0] mv;
  logic         mc;
  always_comb begin
    mv = m_q;
    mc = c_q;
    case (op_q)
      OP_SLO: begin mv = {m_q[MSB-1:0], 1'b0}; mc = m_q[MSB]; end
      OP_RLA: begin mv = {m_q[MSB-1:0], c_q};  mc = m_q[MSB]; end
      OP_SRE: begin mv = {1'b0, m_q[MSB:1]};   mc = m_q[0];   end
      OP_RRA: begin mv = {c_q, m_q[MSB:1]};    mc = m_q[0];   end
      OP_DCP: mv = m_q - W'(1);
      OP_ISB: mv = m_q + W'(1);
      default: ;
    endcase
  end

  wire [W-1:0] ax   = a_q & x_q;
  wire [W-1:0] hinc = h_q + W'(1);

  logic         wsel;
  logic [W-1:0] wval;
  always_comb begin
    wsel = 1'b1;
    wval = mv;
    case (op_q)
      OP_SLO, OP_RLA, OP_SRE, OP_RRA, OP_DCP, OP_ISB: wval = mv;
      OP_SAX: wval = ax;
      OP_SHS: wval = ax & hinc;
      OP_SHX: wval = x_q & hinc;
      default: wsel = 1'b0;
    endcase
  end

  assign wr_en   = (state == ST_MOD) && wsel;
  assign wr_data = wval;

  // accumulator step
  logic [W:0]   ext;
  logic [W-1:0] t, res;
  logic         ea, ex, es, cf, vf;
  logic [3:0]   fm;
  always_comb begin
    ext   = '0;
    t     = '0;
    res   = '0;
    ea    = 1'b0;
    ex    = 1'b0;
    es    = 1'b0;
    cf    = mc;
    vf    = 1'b0;
    fm    = 4'b0000;
    a_out = a_q;
    x_out = x_q;
    s_out = s_q;
    case (op_q)
      OP_SLO: begin res = a_q | mv; ea = 1'b1; fm = 4'b1110; end
      OP_RLA: begin res = a_q & mv; ea = 1'b1; fm = 4'b1110; end
      OP_SRE: begin res = a_q ^ mv; ea = 1'b1; fm = 4'b1110; end
      OP_RRA: begin
        ext = {1'b0, a_q} + {1'b0, mv} + {{W{1'b0}}, mc};
        res = ext[MSB:0];
        cf  = ext[W];
        vf  = (a_q[MSB] == mv[MSB]) && (res[MSB] != a_q[MSB]);
        ea  = 1'b1;
        fm  = 4'b1111;
      end
      OP_DCP: begin
        ext = {1'b0, a_q} - {1'b0, mv};
        res = ext[MSB:0];
        cf  = ~ext[W];
        fm  = 4'b1110;
      end
      OP_ISB: begin
        ext = {1'b0, a_q} - {1'b0, mv} - {{W{1'b0}}, ~c_q};
        res = ext[MSB:0];
        cf  = ~ext[W];
        vf  = (a_q[MSB] != mv[MSB]) && (res[MSB] != a_q[MSB]);
        ea  = 1'b1;
        fm  = 4'b1111;
      end
      OP_LAX: begin res = m_q; ea = 1'b1; ex = 1'b1; fm = 4'b1100; end
      OP_SHS: begin s_out = ax; es = 1'b1; end
      OP_LAS: begin
        res = m_q & s_q;
        ea = 1'b1; ex = 1'b1; es = 1'b1;
        s_out = res;
        fm = 4'b1100;
      end
      OP_SBX: begin
        ext = {1'b0, ax} - {1'b0, m_q};
        res = ext[MSB:0];
        cf  = ~ext[W];
        ex  = 1'b1;
        fm  = 4'b1110;
      end
      OP_ALR: begin
        t = a_q & m_q;
        res = {1'b0, t[MSB:1]};
        cf = t[0];
        ea = 1'b1;
        fm = 4'b1110;
      end
      OP_ARR: begin
        t = a_q & m_q;
        res = {c_q, t[MSB:1]};
        cf = t[0];
        ea = 1'b1;
        fm = 4'b1110;
      end
      default: ;
    endcase
    if (ea) a_out = res;
    if (ex) x_out = res;
  end

  assign done    = (state == ST_ACC);
  assign a_we    = done && ea;
  assign x_we    = done && ex;
  assign s_we    = done && es;
  assign flag_we = done ? fm : 4'b0000;
  assign n_out   = res[MSB];
  assign z_out   = (res == '0);
  assign c_out   = cf;
  assign v_out   = vf;

  a_r1_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_IDLE) |=> ##1 done);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE) |=> state != ST_MOD);
  a_r11_triple_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && s_we && x_we) |-> (a_out == s_out && x_out == s_out));
endmodule

// File: tb/rmw_fuse_alu_bench.sv
module rmw_fuse_alu_bench;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, c_in = 1'b0;
  logic [3:0] op = '0;
  logic [W-1:0] mem_in = '0, a_in = '0, x_in = '0, s_in = '0, hi_in = '0;
  logic wr_en, a_we, x_we, s_we, n_out, z_out, c_out, v_out, done;
  logic [W-1:0] wr_data, a_out, x_out, s_out;
  logic [3:0] flag_we;
  int n_chk = 0, n_bad = 0;

  logic         g_wr;
  logic [W-1:0] g_wd;

  always #5 clk = ~clk;

  rmw_fuse_alu #(.W(W)) u_rmw_fuse_alu (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mem_in(mem_in),
    .a_in(a_in), .x_in(x_in), .s_in(s_in), .c_in(c_in), .hi_in(hi_in),
    .wr_en(wr_en), .wr_data(wr_data), .a_out(a_out), .a_we(a_we),
    .x_out(x_out), .x_we(x_we), .s_out(s_out), .s_we(s_we),
    .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out),
    .flag_we(flag_we), .done(done));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drives one op; leaves the bench at the negedge of the done cycle
  task automatic issue(input logic [3:0] o, input logic [7:0] m, input logic [7:0] a,
                       input logic [7:0] x, input logic [7:0] s, input logic c,
                       input logic [7:0] h);
    @(negedge clk);
    op = o; mem_in = m; a_in = a; x_in = x; s_in = s; c_in = c; hi_in = h; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    g_wr = wr_en; g_wd = wr_data;
    chk("R1 no done in write cycle", int'(done), 0);
    @(negedge clk);
    chk("R1 done after write cycle", int'(done), 1);
  endtask

  task automatic t_reset;
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset wr_en", int'(wr_en), 0);
    chk("R1 reset flag_we", int'(flag_we), 0);
  endtask

  task automatic t_shift_pairs;
    issue(4'd0, 8'hC1, 8'h02, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R3 slo wr", int'(g_wr), 1); chk("R3 slo wd", int'(g_wd), 'h82);
    chk("R3 slo a", int'(a_out), 'h82); chk("R3 slo a_we", int'(a_we), 1);
    chk("R3 slo c", int'(c_out), 1); chk("R3 slo n", int'(n_out), 1);
    chk("R3 slo mask", int'(flag_we), 'b1110);
    issue(4'd1, 8'h81, 8'h0F, 8'h00, 8'h00, 1'b1, 8'h00);
    chk("R3 rla wd", int'(g_wd), 'h03); chk("R3 rla a", int'(a_out), 'h03);
    chk("R3 rla c", int'(c_out), 1);
    issue(4'd2, 8'h03, 8'h01, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R3 sre wd", int'(g_wd), 'h01); chk("R3 sre a", int'(a_out), 'h00);
    chk("R3 sre z", int'(z_out), 1); chk("R3 sre c", int'(c_out), 1);
  endtask

  task automatic t_rra;
    issue(4'd3, 8'h01, 8'h7F, 8'h00, 8'h00, 1'b1, 8'h00);
    chk("R4 rra wd", int'(g_wd), 'h80); chk("R4 rra a", int'(a_out), 'h00);
    chk("R4 rra c", int'(c_out), 1); chk("R4 rra z", int'(z_out), 1);
    chk("R4 rra v", int'(v_out), 0); chk("R4 rra mask", int'(flag_we), 'b1111);
    issue(4'd3, 8'h02, 8'h7F, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R4 rra2 a", int'(a_out), 'h80); chk("R4 rra2 v", int'(v_out), 1);
    chk("R4 rra2 c", int'(c_out), 0); chk("R4 rra2 n", int'(n_out), 1);
  endtask

  task automatic t_dcp;
    issue(4'd4, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R5 dcp wd", int'(g_wd), 'hFF); chk("R5 dcp a_we", int'(a_we), 0);
    chk("R5 dcp z", int'(z_out), 1); chk("R5 dcp c", int'(c_out), 1);
    chk("R5 dcp mask", int'(flag_we), 'b1110);
  endtask

  task automatic t_isb;
    issue(4'd5, 8'hFF, 8'h05, 8'h00, 8'h00, 1'b1, 8'h00);
    chk("R6 isb wd", int'(g_wd), 'h00); chk("R6 isb a", int'(a_out), 'h05);
    chk("R6 isb c", int'(c_out), 1); chk("R6 isb v", int'(v_out), 0);
    issue(4'd5, 8'h00, 8'h80, 8'h00, 8'h00, 1'b1, 8'h00);
    chk("R6 isb2 a", int'(a_out), 'h7F); chk("R6 isb2 v", int'(v_out), 1);
    chk("R6 isb2 c", int'(c_out), 1);
    issue(4'd5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R6 isb3 a", int'(a_out), 'hFE); chk("R6 isb3 c", int'(c_out), 0);
  endtask

  task automatic t_sax;
    issue(4'd6, 8'h55, 8'hF0, 8'h3C, 8'h00, 1'b0, 8'h00);
    chk("R7 sax wr", int'(g_wr), 1); chk("R7 sax wd", int'(g_wd), 'h30);
    chk("R7 sax we", int'({a_we, x_we, s_we}), 0); chk("R7 sax mask", int'(flag_we), 0);
  endtask

  task automatic t_lax;
    issue(4'd7, 8'h80, 8'h11, 8'h22, 8'h00, 1'b0, 8'h00);
    chk("R8 lax wr", int'(g_wr), 0); chk("R8 lax a", int'(a_out), 'h80);
    chk("R8 lax x", int'(x_out), 'h80); chk("R8 lax we", int'({a_we, x_we}), 3);
    chk("R8 lax n", int'(n_out), 1);
  endtask

  task automatic t_shs;
    issue(4'd8, 8'h00, 8'hF3, 8'h3F, 8'h99, 1'b0, 8'h0E);
    chk("R9 shs wd", int'(g_wd), 'h03); chk("R9 shs s", int'(s_out), 'h33);
    chk("R9 shs s_we", int'(s_we), 1); chk("R9 shs mask", int'(flag_we), 0);
  endtask

  task automatic t_shx;
    issue(4'd9, 8'h00, 8'h00, 8'hAB, 8'h00, 1'b0, 8'hFF);
    chk("R10 shx wrap wd", int'(g_wd), 'h00); chk("R10 shx wr", int'(g_wr), 1);
    issue(4'd9, 8'h00, 8'h00, 8'hAB, 8'h00, 1'b0, 8'h0E);
    chk("R10 shx wd", int'(g_wd), 'h0B);
    chk("R10 shx we", int'({a_we, x_we, s_we}), 0);
  endtask

  task automatic t_las;
    issue(4'd10, 8'hF0, 8'h00, 8'h00, 8'h3C, 1'b0, 8'h00);
    chk("R11 las a", int'(a_out), 'h30); chk("R11 las x", int'(x_out), 'h30);
    chk("R11 las s", int'(s_out), 'h30); chk("R11 las we", int'({a_we, x_we, s_we}), 7);
    chk("R11 las wr", int'(g_wr), 0);
  endtask

  task automatic t_sbx;
    issue(4'd11, 8'h0D, 8'h0F, 8'hFC, 8'h00, 1'b1, 8'h00);
    chk("R12 sbx x", int'(x_out), 'hFF); chk("R12 sbx c", int'(c_out), 0);
    chk("R12 sbx n", int'(n_out), 1); chk("R12 sbx a_we", int'(a_we), 0);
    issue(4'd11, 8'h0C, 8'h0F, 8'hFC, 8'h00, 1'b0, 8'h00);
    chk("R12 sbx2 x", int'(x_out), 'h00); chk("R12 sbx2 c", int'(c_out), 1);
  endtask

  task automatic t_alr_arr;
    issue(4'd12, 8'h03, 8'hFF, 8'h00, 8'h00, 1'b1, 8'h00);
    chk("R13 alr a", int'(a_out), 'h01); chk("R13 alr c", int'(c_out), 1);
    issue(4'd13, 8'h03, 8'hFF, 8'h00, 8'h00, 1'b1, 8'h00);
    chk("R13 arr a", int'(a_out), 'h81); chk("R13 arr n", int'(n_out), 1);
    chk("R13 arr c", int'(c_out), 1);
  endtask

  task automatic t_unused;
    issue(4'd14, 8'hAA, 8'h55, 8'h55, 8'h55, 1'b1, 8'h00);
    chk("R14 op14 wr", int'(g_wr), 0);
    chk("R14 op14 we", int'({a_we, x_we, s_we}), 0); chk("R14 op14 mask", int'(flag_we), 0);
    issue(4'd15, 8'hAA, 8'h55, 8'h55, 8'h55, 1'b1, 8'h00);
    chk("R14 op15 wr", int'(g_wr), 0); chk("R14 op15 mask", int'(flag_we), 0);
  endtask

  task automatic t_busy;
    @(negedge clk);
    op = 4'd6; a_in = 8'hF0; x_in = 8'h3C; mem_in = 8'h00; start = 1'b1;
    @(negedge clk);
    chk("R2 first wr", int'(wr_data), 'h30);
    op = 4'd7; mem_in = 8'h80;
    @(negedge clk);
    chk("R2 done", int'(done), 1); chk("R2 no load", int'(a_we), 0);
    @(negedge clk);
    start = 1'b0;
    chk("R2 no second wr", int'(wr_en), 0); chk("R2 idle done", int'(done), 0);
    @(negedge clk);
    chk("R2 still idle wr", int'(wr_en), 0); chk("R2 still idle done", int'(done), 0);
  endtask

  initial begin
    #1 t_reset;
    #30 rst_n = 1'b1;
    t_shift_pairs; t_rra; t_dcp; t_isb; t_sax; t_lax; t_shs; t_shx;
    t_las; t_sbx; t_alr_arr; t_unused; t_busy;
    @(negedge clk);
    chk("R1 idle done", int'(done), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule